// File: doc/BRIEF.md
# Infrared Carrier Waveform Generator

This block produces the square-wave carrier that an infrared remote transmitter modulates with its data. A peripheral clock feeds a power-of-two prescaler, and the prescaler's one-cycle tick is the timebase for the carrier. Two 6-bit lengths set the high and the low part of each carrier period, counted in ticks. Each part lasts its programmed value plus one tick.

A controller sets the divider select and both lengths while `run` is low, then raises `run`. The carrier begins with its high part at once and keeps alternating until `run` falls. While `run` is low the carrier and tick are held low, and the prescaler and phase counter are cleared. The configuration is treated as static while the block runs.

Top module: `ir_carrier_gen`

## Requirements
- R1: With `run` high and `div_sel` = n for n from 0 to 14, `tick` is a one-cycle pulse once every 2^n clock cycles. The first pulse comes in the 2^n-th cycle after `run` rises. With n = 0, `tick` is high in every cycle.
- R2: `div_sel` = 15 (reserved) behaves exactly as `div_sel` = 0, which is divide by 1.
- R3: Each high part of the carrier lasts (`high_len` + 1) ticks, which is (`high_len` + 1) * 2^n clock cycles.
- R4: Each low part of the carrier lasts (`low_len` + 1) ticks, which is (`low_len` + 1) * 2^n clock cycles.
- R5: In the cycle in which `run` first reads high, `carrier` is high. The carrier then alternates high, low, high, and so on.
- R6: While `run` is low, `carrier` and `tick` are 0. A later enable starts again from a cleared prescaler and from the start of the high part.
- R7: While running, `carrier` changes level only after a cycle in which `tick` was high.
- R8: After reset with `run` low, `carrier` and `tick` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Enable. Low halts the block and clears its state |
| div_sel | input | 4 | Prescaler select: code n divides by 2^n; code 15 divides by 1 |
| high_len | input | 6 | Length of the high part, in ticks, minus one |
| low_len | input | 6 | Length of the low part, in ticks, minus one |
| carrier | output | 1 | Carrier waveform |
| tick | output | 1 | Timebase pulse from the prescaler |

## Verification
The hardest case to reach from the ports is the largest divider, code 14. There each tick is 16384 cycles apart, so a full carrier period is long. The bench reaches it with both lengths at zero, which keeps one period within the cycle budget while still checking the widest prescaler mask. Restarting after a halt in the middle of a phase needs `run` to drop at an arbitrary point in a phase. The bench does this and then measures the first high part again, to confirm that it starts at full length.

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int SEL_W = 4,
  parameter int LEN_W = 6,
  parameter int PRE_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [LEN_W-1:0] high_len,
  input  logic [LEN_W-1:0] low_len,
  output logic             carrier,
  output logic             tick
);
  localparam logic [SEL_W-1:0] RSVD = {SEL_W{1'b1}};

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] mask;
  logic [SEL_W-1:0] sel_eff;
  logic [LEN_W-1:0] ph_cnt;
  logic [LEN_W-1:0] ph_lim;
  logic             in_low;

  assign sel_eff = (div_sel == RSVD) ? '0 : div_sel;
  assign mask    = PRE_W'((1 << sel_eff) - 1);
  assign tick    = run && ((pre_cnt & mask) == mask);
  assign ph_lim  = in_low ? low_len : high_len;
  assign carrier = run && !in_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_cnt <= '0;
    else if (!run)
      pre_cnt <= '0;
    else
      pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_cnt <= '0;
      in_low <= 1'b0;
    end else if (!run) begin
      ph_cnt <= '0;
      in_low <= 1'b0;
    end else if (tick) begin
      if (ph_cnt == ph_lim) begin
        ph_cnt <= '0;
        in_low <= !in_low;
      end else begin
        ph_cnt <= ph_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ir_carrier_gen_chk.sv
module ir_carrier_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic [3:0] div_sel,
  input logic       carrier,
  input logic       tick
);
  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!carrier && !tick));

  // R5
  start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> carrier);

  // R7
  edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(tick)) |-> $stable(carrier));

  // R1
  div2_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && div_sel == 4'd1 && $past(div_sel) == 4'd1 && $past(tick)) |-> !tick);
endmodule

bind ir_carrier_gen ir_carrier_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel),
  .carrier(carrier), .tick(tick)
);

// File: tb/ir_carrier_gen_bench.sv
module ir_carrier_gen_bench;
  logic clk = 0, rst_n = 0, run = 0;
  logic [3:0] div_sel = 0;
  logic [5:0] high_len = 0, low_len = 0;
  logic carrier, tick;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ir_carrier_gen u_ir_carrier_gen (.*);

  // {div_sel, high_len, low_len}
  localparam logic [15:0] VEC [7] = '{
    {4'd2, 6'd2,  6'd1},
    {4'd0, 6'd0,  6'd0},
    {4'd0, 6'd63, 6'd5},
    {4'd1, 6'd4,  6'd9},
    {4'd3, 6'd1,  6'd7},
    {4'd5, 6'd10, 6'd3},
    {4'd14, 6'd0, 6'd0}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(logic [3:0] d, logic [5:0] h, logic [5:0] l);
    @(negedge clk); run = 0; div_sel = d; high_len = h; low_len = l;
    @(negedge clk); @(negedge clk);
    run = 1; #1;
  endtask

  task automatic measure(logic lvl, output int n);
    n = 0;
    while (carrier == lvl && n < 100000) begin
      n++; @(negedge clk); #1;
    end
  endtask

  initial begin
    #200000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int hi, lo, hi2, gap, m;
    #45;
    chk("R8 carrier", int'(carrier), 0);
    chk("R8 tick", int'(tick), 0);
    rst_n = 1;
    foreach (VEC[i]) begin
      m = 1 << VEC[i][15:12];
      setup(VEC[i][15:12], VEC[i][11:6], VEC[i][5:0]);
      chk("R5 starts high", int'(carrier), 1);
      measure(1'b1, hi);
      measure(1'b0, lo);
      measure(1'b1, hi2);
      chk("R3 high cycles", hi, (int'(VEC[i][11:6]) + 1) * m);
      chk("R4 low cycles", lo, (int'(VEC[i][5:0]) + 1) * m);
      chk("R5 repeat high", hi2, (int'(VEC[i][11:6]) + 1) * m);
    end
    // R2 reserved code acts as divide by 1
    setup(4'hF, 6'd3, 6'd2);
    measure(1'b1, hi); measure(1'b0, lo);
    chk("R2 high cycles", hi, 4);
    chk("R2 low cycles", lo, 3);
    // R1 tick spacing at divide by 4: first tick in the 4th cycle
    setup(4'd2, 6'd5, 6'd5);
    gap = 0;
    while (!tick && gap < 100) begin gap++; @(negedge clk); #1; end
    chk("R1 first tick", gap + 1, 4);
    @(negedge clk); #1; gap = 1;
    while (!tick && gap < 100) begin gap++; @(negedge clk); #1; end
    chk("R1 tick period", gap, 4);
    // R1 divide by 1 ticks every cycle
    setup(4'd0, 6'd1, 6'd1);
    repeat (3) begin chk("R1 div1 tick", int'(tick), 1); @(negedge clk); #1; end
    // R6 halt mid-phase, outputs low, restart full length
    setup(4'd1, 6'd6, 6'd2);
    repeat (5) @(negedge clk);
    run = 0; #1;
    chk("R6 carrier held low", int'(carrier), 0);
    chk("R6 tick held low", int'(tick), 0);
    repeat (7) begin @(negedge clk); #1; chk("R6 still low", int'(carrier | tick), 0); end
    run = 1; #1;
    measure(1'b1, hi);
    chk("R6 restart high cycles", hi, 14);
    @(negedge clk); run = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule